// File: doc/BRIEF.md
# Linked List Search Engine

This block walks a singly linked list held in a 16-bit, word-addressed memory and looks for a key. Every list entry starts with a link word that holds the address of the next entry. The key of that entry sits a fixed number of words after its link word. The walk ends when the next link is zero, when a link carries a set bit 15 (which marks a corrupted list), or when an entry's key satisfies the chosen match rule.

A caller loads a head pointer, a search value, a key offset and a mode bit, then pulses `start`. The block reads the memory through a single read port that has one cycle of latency. It makes two reads per entry it passes over: the key first, then the link. When it finishes it pulses `done` and presents a three-way outcome. It also reports the pointer to the entry where the walk stopped and the pointer to the entry before it, so that software can splice a new entry in at that point.

Top module: `chain_seeker`

## Requirements
- R1: When `start` is accepted, the block clears bit 15 of `head_ptr` to form the first current pointer and sets the previous pointer to zero. If the first entry matches, the block returns `found` with `cur_ptr` equal to the masked head and `prev_ptr` equal to 0.
- R2: The key of an entry is read from address (current pointer + `key_off`) modulo 2^15. `mem_addr` is 15 bits wide.
- R3: With `mode_gt` = 0, an entry matches when its key equals `search_val`.
- R4: With `mode_gt` = 1, an entry matches when its key, taken as an unsigned 16-bit value, is strictly greater than `search_val`. An equal key does not match.
- R5: When an entry does not match, its link word is read from the current pointer's address. The previous pointer then takes the current pointer, and the current pointer takes the link word. On `found`, `cur_ptr` is the matching entry and `prev_ptr` is the entry before it.
- R6: A current pointer of zero ends the walk with outcome 1 (not found), `cur_ptr` = 0, and `prev_ptr` = the last entry visited (0 if the head was zero).
- R7: A current pointer with bit 15 set ends the walk with outcome 0 (list error). `cur_ptr` holds that faulty link word and `prev_ptr` holds the entry that contained it. Outcome 2 means found. Outcome 3 is never produced.
- R8: `busy` is high from the cycle after `start` is accepted until the result is ready. `done` is a pulse one cycle long during which `busy` is low. `start` has no effect while `busy` is high. The outputs stay unchanged until the next accepted start.
- R9: `mem_rd` is high only while `busy` is high, and each read is a single cycle. A walk that visits N non-null entries performs 2N reads if it ends without a match and 2N-1 reads if it ends on a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; ignored while busy |
| head_ptr | input | 16 | Address of the first entry (bit 15 ignored) |
| search_val | input | 16 | Value to search for |
| key_off | input | 15 | Offset from the link word to the key |
| mode_gt | input | 1 | 0: equal match, 1: unsigned greater-than match |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 2 | 0 list error, 1 not found, 2 found |
| cur_ptr | output | 16 | Stopping entry (or faulty link) |
| prev_ptr | output | 16 | Entry before the stopping entry |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |

## Verification
The bench gives a head with bit 15 set. A design that used it unmasked would report a list error instead of finding the first entry. It places an entry near the top of the address space so that the key address wraps. It probes greater-than mode with a key above 0x7FFF, where a signed comparison would skip the match, and with a key exactly equal to the search value, which must not stop the walk. It builds a list with a corrupted link, a list that ends without a match, and an empty head, and checks the reported pointers in each case, since a swapped or stale predecessor would break later insertion. It also counts read strobes per walk and raises `start` during a busy walk to make sure that walk carries on undisturbed.

// File: rtl/chain_pkg.sv
package chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_EVAL = 3'd1,
    ST_RKEY = 3'd2,
    ST_CMP  = 3'd3,
    ST_LINK = 3'd4
  } walk_state_t;

  typedef enum logic [1:0] {
    RES_ERROR = 2'd0,
    RES_MISS  = 2'd1,
    RES_HIT   = 2'd2
  } walk_result_t;
endpackage

// File: rtl/chain_match.sv
module chain_match #(
  parameter int W = 16
) (
  input  logic [W-1:0] key_word,
  input  logic [W-1:0] target,
  input  logic         gt_mode,
  output logic         hit
);
  logic is_eq;
  logic is_gt;

  always_comb begin
    is_eq = (key_word == target);
    is_gt = (key_word > target);
    hit   = gt_mode ? is_gt : is_eq;
  end
endmodule

// File: rtl/chain_addr.sv
module chain_addr #(
  parameter int AW = 15
) (
  input  logic [AW-1:0] cur_low,
  input  logic [AW-1:0] offset,
  input  logic          link_sel,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] key_addr;

  always_comb begin
    key_addr = cur_low + offset;
    addr     = link_sel ? cur_low : key_addr;
  end
endmodule

// File: rtl/chain_ctrl.sv
module chain_ctrl
  import chain_pkg::*;
#(
  parameter int W  = 16,
  localparam int AW = W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  head_ptr,
  input  logic [W-1:0]  search_val,
  input  logic [AW-1:0] key_off,
  input  logic          mode_gt,
  input  logic          key_hit,
  input  logic [W-1:0]  mem_rdata,
  output logic [W-1:0]  cur_q,
  output logic [W-1:0]  prev_q,
  output logic [W-1:0]  target_q,
  output logic [AW-1:0] off_q,
  output logic          mode_q,
  output logic          rd_en,
  output logic          rd_link,
  output logic          busy,
  output logic          done_q,
  output logic [1:0]    result_q
);
  walk_state_t state_q, state_d;
  logic [W-1:0]  cur_d, prev_d, target_d;
  logic [AW-1:0] off_d;
  logic          mode_d;
  logic          done_d;
  logic [1:0]    result_d;
  logic          ld_cur, ld_cfg, ld_res;

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    prev_d   = prev_q;
    target_d = target_q;
    off_d    = off_q;
    mode_d   = mode_q;
    result_d = result_q;
    done_d   = 1'b0;
    ld_cur   = 1'b0;
    ld_cfg   = 1'b0;
    ld_res   = 1'b0;
    rd_en    = 1'b0;
    rd_link  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cur_d    = {1'b0, head_ptr[AW-1:0]};
          prev_d   = '0;
          target_d = search_val;
          off_d    = key_off;
          mode_d   = mode_gt;
          ld_cur   = 1'b1;
          ld_cfg   = 1'b1;
          state_d  = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (cur_q == '0) begin
          result_d = RES_MISS;
          ld_res   = 1'b1;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end else if (cur_q[W-1]) begin
          result_d = RES_ERROR;
          ld_res   = 1'b1;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          state_d = ST_RKEY;
        end
      end
      ST_RKEY: begin
        rd_en   = 1'b1;
        state_d = ST_CMP;
      end
      ST_CMP: begin
        if (key_hit) begin
          result_d = RES_HIT;
          ld_res   = 1'b1;
          done_d   = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          rd_en   = 1'b1;
          rd_link = 1'b1;
          state_d = ST_LINK;
        end
      end
      ST_LINK: begin
        prev_d  = cur_q;
        cur_d   = mem_rdata;
        ld_cur  = 1'b1;
        state_d = ST_EVAL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (ld_cur) begin
      cur_q  <= cur_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      off_q    <= '0;
      mode_q   <= 1'b0;
    end else if (ld_cfg) begin
      target_q <= target_d;
      off_q    <= off_d;
      mode_q   <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= RES_MISS;
    end else if (ld_res) begin
      result_q <= result_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (prev_q == '0 && cur_q[W-1] == 1'b0)) else $error("start load"); // R1
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LINK) |=> (prev_q == $past(cur_q) && cur_q == $past(mem_rdata))) else $error("advance"); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(target_q)) else $error("start while busy"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done width"); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy) else $error("done while busy"); // R8
  AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy) else $error("read while idle"); // R9
endmodule

// File: rtl/chain_seeker.sv
module chain_seeker
  import chain_pkg::*;
#(
  parameter int W  = 16,
  localparam int AW = W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  head_ptr,
  input  logic [W-1:0]  search_val,
  input  logic [AW-1:0] key_off,
  input  logic          mode_gt,
  output logic          busy,
  output logic          done,
  output logic [1:0]    outcome,
  output logic [W-1:0]  cur_ptr,
  output logic [W-1:0]  prev_ptr,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [W-1:0]  mem_rdata
);
  logic [W-1:0]  cur_q, prev_q, target_q;
  logic [AW-1:0] off_q;
  logic          mode_q, rd_link, key_hit;

  chain_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .head_ptr   (head_ptr),
    .search_val (search_val),
    .key_off    (key_off),
    .mode_gt    (mode_gt),
    .key_hit    (key_hit),
    .mem_rdata  (mem_rdata),
    .cur_q      (cur_q),
    .prev_q     (prev_q),
    .target_q   (target_q),
    .off_q      (off_q),
    .mode_q     (mode_q),
    .rd_en      (mem_rd),
    .rd_link    (rd_link),
    .busy       (busy),
    .done_q     (done),
    .result_q   (outcome)
  );

  chain_addr #(.AW(AW)) u_addr (
    .cur_low  (cur_q[AW-1:0]),
    .offset   (off_q),
    .link_sel (rd_link),
    .addr     (mem_addr)
  );

  chain_match #(.W(W)) u_match (
    .key_word (mem_rdata),
    .target   (target_q),
    .gt_mode  (mode_q),
    .hit      (key_hit)
  );

  assign cur_ptr  = cur_q;
  assign prev_ptr = prev_q;

  AST_LINK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && rd_link) |-> (mem_addr == cur_ptr[AW-1:0])) else $error("link addr"); // R5
  AST_NO_READ_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (cur_ptr != '0 && !cur_ptr[W-1])) else $error("read of null"); // R2
  AST_ERR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == RES_ERROR) |-> cur_ptr[W-1]) else $error("error sign"); // R7
  AST_MISS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && outcome == RES_MISS) |-> (cur_ptr == '0)) else $error("miss ptr"); // R6
  AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (outcome != 2'd3)) else $error("code 3"); // R7
endmodule

// File: tb/chain_seeker_tb.sv
module chain_seeker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] head_ptr = '0;
  logic [15:0] search_val = '0;
  logic [14:0] key_off = '0;
  logic        mode_gt = 1'b0;
  logic        busy, done, mem_rd;
  logic [1:0]  outcome;
  logic [15:0] cur_ptr, prev_ptr, mem_rdata;
  logic [14:0] mem_addr;

  logic [15:0] mem [4096];
  logic [15:0] rdata_q = '0;
  int          rd_total = 0;
  int          cycles = 0;
  int          n_chk = 0;
  int          n_bad = 0;

  logic [1:0]  r_out;
  logic [15:0] r_cur, r_prev;
  int          r_reads;
  logic        r_busy1, r_done_after;

  always #2 clk = ~clk;

  chain_seeker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr),
    .search_val(search_val), .key_off(key_off), .mode_gt(mode_gt),
    .busy(busy), .done(done), .outcome(outcome), .cur_ptr(cur_ptr),
    .prev_ptr(prev_ptr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd) begin
      rdata_q  <= mem[mem_addr[11:0]];
      rd_total <= rd_total + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(input logic [15:0] h, input logic [15:0] v, input logic [14:0] o,
                     input logic m, input bit poke);
    int base;
    int waited;
    @(negedge clk);
    head_ptr = h; search_val = v; key_off = o; mode_gt = m; start = 1'b1;
    base = rd_total;
    @(negedge clk);
    start = 1'b0;
    r_busy1 = busy;
    waited = 0;
    while (!done && waited < 300) begin
      if (poke && waited == 2) begin
        head_ptr = 16'h0000; search_val = 16'h1111; mode_gt = ~m; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R8: done missing, got 0 expected 1");
    end
    r_out = outcome; r_cur = cur_ptr; r_prev = prev_ptr; r_reads = rd_total - base;
    @(negedge clk);
    r_done_after = done;
  endtask

  task automatic t_reset();
    chk("R8 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R9 reset mem_rd", mem_rd, 0);
  endtask

  task automatic t_head_sign();
    clear_mem();
    mem[12'h100] = 16'h0000; mem[12'h102] = 16'd55;
    run(16'h8100, 16'd55, 15'd2, 1'b0, 1'b0);
    chk("R1 outcome", r_out, 2);
    chk("R1 cur", r_cur, 16'h0100);
    chk("R1 prev", r_prev, 16'h0000);
    chk("R9 reads one entry hit", r_reads, 1);
    chk("R8 busy after start", r_busy1, 1);
    chk("R8 done one cycle", r_done_after, 0);
  endtask

  task automatic build_three();
    clear_mem();
    mem[12'h200] = 16'h0210; mem[12'h203] = 16'd10;
    mem[12'h210] = 16'h0220; mem[12'h213] = 16'd20;
    mem[12'h220] = 16'h0000; mem[12'h223] = 16'd30;
  endtask

  task automatic t_eq_walk();
    build_three();
    run(16'h0200, 16'd30, 15'd3, 1'b0, 1'b0);
    chk("R3 outcome", r_out, 2);
    chk("R5 cur", r_cur, 16'h0220);
    chk("R5 prev", r_prev, 16'h0210);
    chk("R9 reads 3 entries hit", r_reads, 5);
  endtask

  task automatic t_eq_miss();
    build_three();
    run(16'h0200, 16'd25, 15'd3, 1'b0, 1'b0);
    chk("R6 outcome", r_out, 1);
    chk("R6 cur", r_cur, 16'h0000);
    chk("R6 prev", r_prev, 16'h0220);
    chk("R9 reads 3 entries miss", r_reads, 6);
  endtask

  task automatic t_gt();
    build_three();
    run(16'h0200, 16'd15, 15'd3, 1'b1, 1'b0);
    chk("R4 gt outcome", r_out, 2);
    chk("R4 gt cur", r_cur, 16'h0210);
    chk("R4 gt prev", r_prev, 16'h0200);
    run(16'h0200, 16'd30, 15'd3, 1'b1, 1'b0);
    chk("R4 equal not greater", r_out, 1);
    chk("R4 equal prev", r_prev, 16'h0220);
    clear_mem();
    mem[12'h300] = 16'h0310; mem[12'h301] = 16'h0005;
    mem[12'h310] = 16'h0000; mem[12'h311] = 16'h9000;
    run(16'h0300, 16'h7000, 15'd1, 1'b1, 1'b0);
    chk("R4 unsigned outcome", r_out, 2);
    chk("R4 unsigned cur", r_cur, 16'h0310);
  endtask

  task automatic t_error();
    clear_mem();
    mem[12'h400] = 16'h0410; mem[12'h401] = 16'd1;
    mem[12'h410] = 16'h8123; mem[12'h411] = 16'd2;
    run(16'h0400, 16'd9, 15'd1, 1'b0, 1'b0);
    chk("R7 outcome", r_out, 0);
    chk("R7 cur", r_cur, 16'h8123);
    chk("R7 prev", r_prev, 16'h0410);
  endtask

  task automatic t_empty();
    clear_mem();
    run(16'h0000, 16'd0, 15'd1, 1'b0, 1'b0);
    chk("R6 empty outcome", r_out, 1);
    chk("R6 empty prev", r_prev, 16'h0000);
    chk("R9 empty reads", r_reads, 0);
    run(16'h8000, 16'd0, 15'd1, 1'b0, 1'b0);
    chk("R1 masked head empty", r_out, 1);
  endtask

  task automatic t_wrap();
    clear_mem();
    mem[12'hFF0] = 16'h0000;
    mem[12'h010] = 16'hABCD;
    run(16'h7FF0, 16'hABCD, 15'h0020, 1'b0, 1'b0);
    chk("R2 wrap outcome", r_out, 2);
    chk("R2 wrap cur", r_cur, 16'h7FF0);
  endtask

  task automatic t_start_busy();
    build_three();
    run(16'h0200, 16'd30, 15'd3, 1'b0, 1'b1);
    chk("R8 ignored start outcome", r_out, 2);
    chk("R8 ignored start cur", r_cur, 16'h0220);
    chk("R8 ignored start prev", r_prev, 16'h0210);
    repeat (3) @(negedge clk);
    chk("R8 outputs held", cur_ptr, 16'h0220);
    chk("R8 stays idle", busy, 0);
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_head_sign();
    t_eq_walk();
    t_eq_miss();
    t_gt();
    t_error();
    t_empty();
    t_wrap();
    t_start_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule